// File: doc/BRIEF.md
# Dual-Rate System Clock Divider

This block turns a fast base clock into a divided system clock enable: one pulse, one base-clock cycle wide, per divided period. It holds two divide settings, one for a high rate and one for a low rate. A source-select bit picks which one is in force. A demand mode can also take the low rate back up to the high rate for as long as an internal controller reports that it is busy, and drop it again once the controller goes idle.

One write port loads both divide codes and both control bits in a single byte. A change of ratio or source takes effect only when the current divided period ends. The output therefore never shows a shortened period. A status output tells which rate is in force, and a second flag tells whether the most recent write carried a reserved code.

Top module: `dual_rate_clkdiv`

## Requirements
- R1: After reset both codes and both control bits are zero, so `clkEn` is high on every cycle, `lowRateActive` is 0 and `wrIgnored` is 0.
- R2: With `srcSel` (wrData bit 6) at 0, the high-rate code in wrData[2:0] gives a period of 2^code base cycles for codes 0 to 6.
- R3: With `srcSel` at 1 and the demand mode not pulling the rate up, the low-rate code in wrData[5:3] gives 2^(code+1) cycles for codes 0 to 5, and 256 cycles for code 7. At the low rate `clkEn` is never high on two cycles in a row.
- R4: A write with high-rate code 7 (reserved) leaves the previous high-rate code in use. The other fields of that write still take effect.
- R5: A write with low-rate code 6 (reserved) leaves the previous low-rate code in use. The other fields of that write still take effect.
- R6: From the cycle after each write, `wrIgnored` shows whether that write held a reserved code in either field. It keeps that value until the next write.
- R7: With `reqEn` (wrData bit 7) at 1 and `srcSel` at 1, the high-rate period applies while `ctrlBusy` is 1, and the low-rate period applies while it is 0.
- R8: With `reqEn` at 0 and `srcSel` at 1, `ctrlBusy` has no effect on the period or on the status.
- R9: A new ratio or source takes effect only at the end of the divided period that is running. Every output period is a whole power of two.
- R10: `lowRateActive` reports the rate of the period in progress. It changes only on the clock edge that ends a period.
- R11: `clkEn` is a single-cycle pulse per period, and it is held high continuously at divide-by-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the control byte |
| wrData | input | 8 | [2:0] high-rate code, [5:3] low-rate code, [6] srcSel, [7] reqEn |
| ctrlBusy | input | 1 | Controller busy request |
| clkEn | output | 1 | Divided clock-enable pulse |
| lowRateActive | output | 1 | 1 while the low rate is in force |
| wrIgnored | output | 1 | Last write carried a reserved code |

## Verification
The bench changes the setting in the middle of a 256-cycle period and checks that the first period after the change still lasts 256 cycles. A design that switched at once would produce a short period, and would also flip the status flag too early. The bench writes each reserved code right after a valid one and measures the period that follows. A design that decoded the reserved code would run at some other ratio, or would lose the fields written alongside it. The bench also toggles the busy input with the demand mode both on and off. A design that ignores the mode bit would, in one of the two cases, run at the wrong rate.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int MAX_SHIFT = 8;
  localparam int SHIFT_W   = $clog2(MAX_SHIFT + 1);

  typedef struct packed {
    logic [SHIFT_W-1:0] shift;   // log2 of the wanted period
    logic               useLow;  // wanted period comes from the low-rate code
  } divTarget_t;
endpackage

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
  import clkdiv_pkg::*;
#(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2*CODE_W+1:0] wrData,
  input  logic              ctrlBusy,
  output divTarget_t        target,
  output logic              wrIgnored
);
  localparam logic [CODE_W-1:0] HI_RSVD = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] LO_RSVD = {{(CODE_W-1){1'b1}}, 1'b0};
  localparam logic [CODE_W-1:0] LO_TOP  = {CODE_W{1'b1}};

  logic [CODE_W-1:0] hiCode, loCode;
  logic              srcSel, reqEn;

  logic [CODE_W-1:0] wrHi, wrLo;
  logic              hiBad, loBad;

  assign wrHi  = wrData[CODE_W-1:0];
  assign wrLo  = wrData[2*CODE_W-1:CODE_W];
  assign hiBad = (wrHi == HI_RSVD);
  assign loBad = (wrLo == LO_RSVD);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiCode    <= '0;
      loCode    <= '0;
      srcSel    <= 1'b0;
      reqEn     <= 1'b0;
      wrIgnored <= 1'b0;
    end else if (wrEn) begin
      if (!hiBad) hiCode <= wrHi;
      if (!loBad) loCode <= wrLo;
      srcSel    <= wrData[2*CODE_W];
      reqEn     <= wrData[2*CODE_W+1];
      wrIgnored <= hiBad | loBad;
    end
  end

  logic [SHIFT_W-1:0] hiShift, loShift;

  always_comb begin
    hiShift = SHIFT_W'(hiCode);
    if (loCode == LO_TOP) loShift = SHIFT_W'(MAX_SHIFT);
    else                  loShift = SHIFT_W'(loCode) + SHIFT_W'(1);
  end

  always_comb begin
    target.useLow = srcSel & ~(reqEn & ctrlBusy);
    target.shift  = target.useLow ? loShift : hiShift;
  end
endmodule

// File: rtl/clkdiv_datapath.sv
module clkdiv_datapath
  import clkdiv_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  divTarget_t target,
  output logic       clkEn,
  output logic       lowRateActive
);
  localparam int CNT_W = MAX_SHIFT;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   periodFull;
  logic [CNT_W-1:0] reload;

  assign periodFull = (CNT_W+1)'(1) << target.shift;
  assign reload     = CNT_W'(periodFull - (CNT_W+1)'(1));
  assign clkEn      = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt           <= '0;
      lowRateActive <= 1'b0;
    end else if (clkEn) begin
      cnt           <= reload;
      lowRateActive <= target.useLow;
    end else begin
      cnt <= cnt - CNT_W'(1);
    end
  end
endmodule

// File: rtl/dual_rate_clkdiv.sv
module dual_rate_clkdiv
  import clkdiv_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       ctrlBusy,
  output logic       clkEn,
  output logic       lowRateActive,
  output logic       wrIgnored
);
  divTarget_t target;

  clkdiv_ctrl #(.CODE_W(3)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .ctrlBusy(ctrlBusy), .target(target), .wrIgnored(wrIgnored)
  );

  clkdiv_datapath u_dp (
    .clk(clk), .rstN(rstN), .target(target),
    .clkEn(clkEn), .lowRateActive(lowRateActive)
  );
endmodule

// File: rtl/dual_rate_clkdiv_chk.sv
module dual_rate_clkdiv_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [7:0] wrData,
  input logic       clkEn,
  input logic       lowRateActive,
  input logic       wrIgnored
);
  logic [8:0] gap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      gap <= '0;
    else if (clkEn) gap <= '0;
    else if (gap != 9'h1FF) gap <= gap + 9'd1;
  end

  AST_PERIOD_POW2: assert property (@(posedge clk) disable iff (!rstN)
    clkEn |-> ($countones({1'b0, gap} + 10'd1) == 1 && gap < 9'd256)); // R9

  AST_STATUS_AT_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(lowRateActive) |-> $past(clkEn)); // R10

  AST_LOW_NOT_CONTINUOUS: assert property (@(posedge clk) disable iff (!rstN)
    clkEn |=> (!lowRateActive || !clkEn)); // R3

  AST_RSVD_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (wrData[2:0] == 3'b111 || wrData[5:3] == 3'b110)) |=> wrIgnored); // R6

  AST_CLEAN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[2:0] != 3'b111 && wrData[5:3] != 3'b110) |=> !wrIgnored); // R6

  AST_FLAG_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(wrIgnored)); // R6
endmodule

bind dual_rate_clkdiv dual_rate_clkdiv_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
  .clkEn(clkEn), .lowRateActive(lowRateActive), .wrIgnored(wrIgnored)
);

// File: tb/dual_rate_clkdiv_tb.sv
module dual_rate_clkdiv_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 11;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       ctrlBusy = 1'b0;
  logic       clkEn, lowRateActive, wrIgnored;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_rate_clkdiv u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .ctrlBusy(ctrlBusy), .clkEn(clkEn), .lowRateActive(lowRateActive),
    .wrIgnored(wrIgnored)
  );

  // {wrData, busy, expIgnored, expLow, expPeriod[8:0]}
  localparam logic [19:0] VEC [NVEC] = '{
    {8'h00, 1'b0, 1'b0, 1'b0, 9'd1},    // R2 hi0 /1, R11
    {8'h03, 1'b0, 1'b0, 1'b0, 9'd8},    // R2 hi3
    {8'h06, 1'b0, 1'b0, 1'b0, 9'd64},   // R2 hi6
    {8'h07, 1'b0, 1'b1, 1'b0, 9'd64},   // R4 reserved hi kept
    {8'h42, 1'b0, 1'b0, 1'b1, 9'd2},    // R3 lo0
    {8'h6A, 1'b0, 1'b0, 1'b1, 9'd64},   // R3 lo5
    {8'h7A, 1'b0, 1'b0, 1'b1, 9'd256},  // R3 lo7
    {8'h72, 1'b0, 1'b1, 1'b1, 9'd256},  // R5 reserved lo kept
    {8'h52, 1'b1, 1'b0, 1'b1, 9'd8},    // R8 busy without reqEn
    {8'hD2, 1'b1, 1'b0, 1'b0, 9'd4},    // R7 busy pulls up to hi
    {8'hD2, 1'b0, 1'b0, 1'b1, 9'd8}     // R7 idle back to lo
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeCfg(input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1;
    wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // waits for a pulse, then counts cycles to the next pulse
  task automatic measure(output int n);
    while (!clkEn) @(negedge clk);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!clkEn);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int p;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R1 clkEn", clkEn, 1);
    end
    check("R1 lowRateActive", lowRateActive, 0);
    check("R1 wrIgnored", wrIgnored, 0);

    for (int i = 0; i < NVEC; i++) begin
      ctrlBusy = VEC[i][11];
      writeCfg(VEC[i][19:12]);
      check("R6 wrIgnored", wrIgnored, int'(VEC[i][10]));
      measure(p);
      check("R2/R3/R4/R5/R7/R8 period", p, int'(VEC[i][8:0]));
      check("R10 lowRateActive", lowRateActive, int'(VEC[i][9]));
    end
    ctrlBusy = 1'b0;

    // R9/R10: switch mid-period from /256 low to /1 high
    writeCfg(8'h7A);
    measure(p);
    check("R3 lo7 period", p, 256);
    repeat (10) @(negedge clk);
    writeCfg(8'h00);
    check("R10 status held mid-period", lowRateActive, 1);
    check("R9 no early pulse", clkEn, 0);
    p = 12;
    while (!clkEn) begin
      @(negedge clk);
      p++;
    end
    check("R9 period completed", p, 256);
    @(negedge clk);
    check("R10 status after edge", lowRateActive, 0);
    check("R11 div1 continuous", clkEn, 1);
    @(negedge clk);
    check("R11 div1 continuous", clkEn, 1);

    // R11 single-cycle pulse at /2 high
    writeCfg(8'h01);
    measure(p);
    check("R2 hi1 period", p, 2);
    @(negedge clk);
    check("R11 pulse one cycle", clkEn, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule